// File: doc/BRIEF.md
# Q-learning voltage level selector

This controller picks one of a small set of supply voltage levels once per control interval. It keeps a table of signed scores with one row for each voltage level and one column for each quantized slack reading from an on-chip delay monitor. When a decision is requested, the controller latches the current slack code and scans the matching column one row per cycle. It then moves to the level with the highest score and reports the normalized power reward of that move, so that an external penalty unit can use it.

Once the supply has settled at the new level, the monitor provides a fresh slack code and the penalty unit provides a penalty magnitude. The controller then applies a temporal-difference update to the score of the state it just left. The penalty is applied only when the fresh slack shows a timing violation. All arithmetic uses Q1.15 fixed point, which saturates at its limits. The learning rate is a power-of-two shift. A start strobe clears everything the controller has learned.

Top module: `qvs_ctrl`

## Requirements
- R1: After reset, and in the cycle after `start_i` is sampled, `vlevel_o` is NV-1 (the highest voltage), `dec_valid_o` is low and every score is zero. As a result, the first decision in any column selects level 0.
- R2: A slack code c in 1..NS addresses column c-1. Code 0 means zero or negative slack and addresses column 0. Codes above NS address column NS-1.
- R3: A decision selects the row with the largest signed score in the addressed column. A tie goes to the lowest level index. `vlevel_o` is always below NV and changes only when a decision completes or after a start.
- R4: `dec_valid_o` is high for exactly one cycle. It rises NV clock edges after the edge that samples `decide_i` in the idle state. `vlevel_o` and `reward_o` take their new values at that same edge.
- R5: Level index n stands for the voltage (VLO + n·VSTEP)·0.1 V. For a move from level i to level j, `reward_o` is ((vi² − vj²)·32768 / (vmax² − vmin²)) truncated toward zero and limited to 32767. The voltages vi, vj, vmax and vmin are in units of 0.1 V. The reward is negative for an upward move and zero for no move, and it holds until the next decision.
- R6: A `post_valid_i` sampled after a decision updates the old state's score as Q ← Q + floor((R − P + Q′ − Q) / 2^ALPHA_SH). Q′ is the score of the new level in the same column, read before the write.
- R7: P equals `penalty_i` when `post_slack_i` is 0. For any other code, P is zero.
- R8: Updated scores saturate to the range −32768..32767 and never wrap.
- R9: A `decide_i` during a scan or while an update is pending has no effect. A `post_valid_i` when no decision is pending has no effect.
- R10: `start_i` at any time abandons a scan or a pending update. It returns the controller to idle at level NV-1 with all scores zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the learned table and returns to idle |
| decide_i | input | 1 | Requests a voltage decision (accepted when idle) |
| slack_i | input | $clog2(NS+1) | Slack code sampled together with `decide_i` |
| post_valid_i | input | 1 | Marks the slack reading taken after the voltage move |
| post_slack_i | input | $clog2(NS+1) | Slack code after the move; 0 means violation |
| penalty_i | input | 15 | Penalty magnitude in Q1.15 |
| vlevel_o | output | $clog2(NV) | Selected voltage level index |
| reward_o | output | 16 | Signed Q1.15 reward of the last move |
| dec_valid_o | output | 1 | One-cycle strobe when a decision completes |

## Verification
The checker assumes that the surrounding logic issues a new request only after the previous one has finished. A decision is requested only from idle, and the post-move reading arrives only while an update is pending. Requests that arrive early are dropped by design, so the checker flags an accepted request that breaks this order. The stimulus runs each interval as a fixed sequence: decide, wait for the strobe, then deliver the post-move reading. Deliberately early strobes appear only in the scenarios that test rejection, and the scenarios that test restart place `start_i` mid-interval.

// File: rtl/qvs_pkg.sv
`timescale 1ns/1ps
package qvs_pkg;
  localparam int Q_W    = 16;
  localparam int Q_FRAC = Q_W - 1;
  localparam int EW     = Q_W + 4;
  localparam int Q_MAX  = (1 << Q_FRAC) - 1;
  localparam int Q_MIN  = -(1 << Q_FRAC);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT} qvs_state_e;

  // normalized power change of a move between voltage codes (0.1 V units)
  function automatic logic signed [Q_W-1:0] reward_q(input int vi, input int vj,
                                                     input int vlo, input int vhi);
    int num;
    int den;
    int r;
    den = vhi * vhi - vlo * vlo;
    num = (vi * vi - vj * vj) * (1 << Q_FRAC);
    r   = (den == 0) ? 0 : num / den;
    if (r > Q_MAX) r = Q_MAX;
    if (r < Q_MIN) r = Q_MIN;
    return Q_W'(r);
  endfunction

  // slack code to table column
  function automatic int col_of(input int code, input int ns);
    if (code == 0) return 0;
    if (code > ns) return ns - 1;
    return code - 1;
  endfunction

  // learning target R - P + Q', widened
  function automatic logic signed [EW-1:0] td_target(input logic signed [Q_W-1:0] r,
                                                     input logic signed [Q_W-1:0] q,
                                                     input logic [Q_W-2:0] p,
                                                     input logic p_en);
    logic signed [EW-1:0] acc;
    acc = EW'(r) + EW'(q);
    if (p_en) acc = acc - $signed({{(EW-Q_W+1){1'b0}}, p});
    return acc;
  endfunction

  // clamp a widened value into Q1.15
  function automatic logic signed [Q_W-1:0] sat_q(input logic signed [EW-1:0] n);
    if (n[EW-1:Q_W-1] == '0 || n[EW-1:Q_W-1] == '1) return n[Q_W-1:0];
    return n[EW-1] ? {1'b1, {(Q_W-1){1'b0}}} : {1'b0, {(Q_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/qvs_table.sv
`timescale 1ns/1ps
module qvs_table import qvs_pkg::*; #(
  parameter int NV = 5,
  parameter int NS = 10,
  localparam int RW = (NV > 1) ? $clog2(NV) : 1,
  localparam int CW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [RW-1:0]         a_row,
  input  logic [CW-1:0]         a_col,
  output logic signed [Q_W-1:0] a_val,
  input  logic [RW-1:0]         b_row,
  input  logic [RW-1:0]         c_row,
  input  logic [CW-1:0]         bc_col,
  output logic signed [Q_W-1:0] b_val,
  output logic signed [Q_W-1:0] c_val,
  input  logic                  we,
  input  logic [RW-1:0]         w_row,
  input  logic [CW-1:0]         w_col,
  input  logic signed [Q_W-1:0] w_val
);
  logic signed [Q_W-1:0] score [NV][NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NV; r++)
        for (int c = 0; c < NS; c++)
          score[r][c] <= '0;
    end else if (clr) begin
      for (int r = 0; r < NV; r++)
        for (int c = 0; c < NS; c++)
          score[r][c] <= '0;
    end else if (we) begin
      score[w_row][w_col] <= w_val;
    end
  end

  assign a_val = score[a_row][a_col];
  assign b_val = score[b_row][bc_col];
  assign c_val = score[c_row][bc_col];
endmodule

// File: rtl/qvs_argmax.sv
`timescale 1ns/1ps
module qvs_argmax import qvs_pkg::*; #(
  parameter int NV = 5,
  localparam int RW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  go,
  output logic [RW-1:0]         rd_row,
  input  logic signed [Q_W-1:0] rd_val,
  output logic                  done,
  output logic [RW-1:0]         win_row
);
  logic                  active;
  logic [RW-1:0]         row;
  logic [RW-1:0]         best_row;
  logic signed [Q_W-1:0] best_val;
  logic                  take;

  // strict compare keeps the earliest (lowest) row on ties
  assign take    = (row == '0) || (rd_val > best_val);
  assign done    = active && (row == RW'(NV-1));
  assign win_row = take ? row : best_row;
  assign rd_row  = row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      row      <= '0;
      best_row <= '0;
      best_val <= '0;
    end else if (abort) begin
      active <= 1'b0;
      row    <= '0;
    end else if (go) begin
      active <= 1'b1;
      row    <= '0;
    end else if (active) begin
      if (take) begin
        best_val <= rd_val;
        best_row <= row;
      end
      if (done) begin
        active <= 1'b0;
        row    <= '0;
      end else begin
        row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qvs_update.sv
`timescale 1ns/1ps
module qvs_update import qvs_pkg::*; #(
  parameter int SH = 2
) (
  input  logic signed [Q_W-1:0] q_old,
  input  logic signed [Q_W-1:0] q_tgt,
  input  logic signed [Q_W-1:0] rwd,
  input  logic [Q_W-2:0]        pen,
  input  logic                  pen_en,
  output logic signed [Q_W-1:0] q_new
);
  logic signed [EW-1:0] tgt_e;
  logic signed [EW-1:0] diff_e;
  logic signed [EW-1:0] sum_e;

  always_comb begin
    tgt_e  = td_target(rwd, q_tgt, pen, pen_en);
    diff_e = tgt_e - EW'(q_old);
    sum_e  = EW'(q_old) + (diff_e >>> SH);
    q_new  = sat_q(sum_e);
  end
endmodule

// File: rtl/qvs_ctrl.sv
`timescale 1ns/1ps
module qvs_ctrl import qvs_pkg::*; #(
  parameter int NV       = 5,
  parameter int NS       = 10,
  parameter int VLO      = 8,
  parameter int VSTEP    = 1,
  parameter int ALPHA_SH = 2,
  localparam int RW  = (NV > 1) ? $clog2(NV) : 1,
  localparam int CW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int SCW = $clog2(NS + 1),
  localparam int VHI = VLO + (NV - 1) * VSTEP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  decide_i,
  input  logic [SCW-1:0]        slack_i,
  input  logic                  post_valid_i,
  input  logic [SCW-1:0]        post_slack_i,
  input  logic [Q_W-2:0]        penalty_i,
  output logic [RW-1:0]         vlevel_o,
  output logic signed [Q_W-1:0] reward_o,
  output logic                  dec_valid_o
);
  qvs_state_e            st;
  logic [RW-1:0]         lvl;
  logic [RW-1:0]         from_lvl;
  logic [CW-1:0]         cur_col;
  logic signed [Q_W-1:0] rwd;
  logic                  dval;

  // named events for the checker
  logic                  decide_acc;
  logic                  post_acc;
  logic                  scan_done;
  logic [RW-1:0]         win_row;
  logic [RW-1:0]         scan_row;
  logic signed [Q_W-1:0] scan_val;
  logic signed [Q_W-1:0] q_old;
  logic signed [Q_W-1:0] q_tgt;
  logic signed [Q_W-1:0] q_new;
  logic                  pen_en;

  // reward ROM, computed from the voltage grid
  logic signed [Q_W-1:0] rom [NV][NV];
  for (genvar gi = 0; gi < NV; gi++) begin : g_rom_row
    for (genvar gj = 0; gj < NV; gj++) begin : g_rom_col
      assign rom[gi][gj] = reward_q(VLO + gi * VSTEP, VLO + gj * VSTEP, VLO, VHI);
    end
  end

  assign decide_acc = decide_i && (st == ST_IDLE) && !start_i;
  assign post_acc   = post_valid_i && (st == ST_WAIT) && !start_i;
  assign pen_en     = (post_slack_i == '0);

  qvs_table #(.NV(NV), .NS(NS)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_i),
    .a_row  (scan_row),
    .a_col  (cur_col),
    .a_val  (scan_val),
    .b_row  (from_lvl),
    .c_row  (lvl),
    .bc_col (cur_col),
    .b_val  (q_old),
    .c_val  (q_tgt),
    .we     (post_acc),
    .w_row  (from_lvl),
    .w_col  (cur_col),
    .w_val  (q_new)
  );

  qvs_argmax #(.NV(NV)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (start_i),
    .go      (decide_acc),
    .rd_row  (scan_row),
    .rd_val  (scan_val),
    .done    (scan_done),
    .win_row (win_row)
  );

  qvs_update #(.SH(ALPHA_SH)) u_upd (
    .q_old  (q_old),
    .q_tgt  (q_tgt),
    .rwd    (rwd),
    .pen    (penalty_i),
    .pen_en (pen_en),
    .q_new  (q_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lvl      <= RW'(NV - 1);
      from_lvl <= RW'(NV - 1);
      cur_col  <= '0;
      rwd      <= '0;
      dval     <= 1'b0;
    end else if (start_i) begin
      st       <= ST_IDLE;
      lvl      <= RW'(NV - 1);
      from_lvl <= RW'(NV - 1);
      dval     <= 1'b0;
    end else begin
      dval <= 1'b0;
      unique case (st)
        ST_IDLE: if (decide_acc) begin
          cur_col  <= CW'(col_of(int'(slack_i), NS));
          from_lvl <= lvl;
          st       <= ST_SCAN;
        end
        ST_SCAN: if (scan_done) begin
          lvl  <= win_row;
          rwd  <= rom[from_lvl][win_row];
          dval <= 1'b1;
          st   <= ST_WAIT;
        end
        ST_WAIT: if (post_acc) begin
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign vlevel_o    = lvl;
  assign reward_o    = rwd;
  assign dec_valid_o = dval;
endmodule

// File: rtl/qvs_ctrl_chk.sv
`timescale 1ns/1ps
module qvs_ctrl_chk import qvs_pkg::*; #(
  parameter int NV = 5,
  parameter int RW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  decide_acc,
  input logic                  post_acc,
  input logic                  scan_done,
  input logic                  dec_valid_o,
  input logic [RW-1:0]         vlevel_o,
  input logic signed [Q_W-1:0] reward_o
);
  logic       busy;
  logic       pend;
  logic [7:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      lat  <= '0;
    end else if (start_i) begin
      busy <= 1'b0;
      pend <= 1'b0;
      lat  <= '0;
    end else begin
      if (decide_acc) begin
        busy <= 1'b1;
        lat  <= '0;
      end else if (busy) begin
        lat <= lat + 8'd1;
      end
      if (dec_valid_o) begin
        busy <= 1'b0;
        pend <= 1'b1;
      end
      if (post_acc) pend <= 1'b0;
    end
  end

  AST_DECIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> (busy && lat == 8'(NV))); // R4
  AST_DECIDE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat == 8'(NV)) |-> dec_valid_o); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> !dec_valid_o); // R4
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vlevel_o < RW'(NV)); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vlevel_o) |-> (dec_valid_o || $past(start_i))); // R3
  AST_REWARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> (((reward_o < 0) == (vlevel_o > $past(vlevel_o))) &&
                     ((reward_o == 0) == (vlevel_o == $past(vlevel_o))))); // R5
  AST_NO_EARLY_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    decide_acc |-> (!busy && !pend)); // R9
  AST_NO_STRAY_POST: assert property (@(posedge clk) disable iff (!rst_n)
    post_acc |-> (pend || dec_valid_o)); // R9
  AST_SCAN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> busy); // R10
endmodule

bind qvs_ctrl qvs_ctrl_chk #(.NV(NV), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .decide_acc  (decide_acc),
  .post_acc    (post_acc),
  .scan_done   (scan_done),
  .dec_valid_o (dec_valid_o),
  .vlevel_o    (vlevel_o),
  .reward_o    (reward_o)
);

// File: tb/tb_qvs_ctrl.sv
`timescale 1ns/1ps
module tb_qvs_ctrl;
  localparam int NV = 5;
  localparam int NS = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic               decide_i = 1'b0;
  logic [3:0]         slack_i = '0;
  logic               post_valid_i = 1'b0;
  logic [3:0]         post_slack_i = '0;
  logic [14:0]        penalty_i = '0;
  logic [2:0]         vlevel_o;
  logic signed [15:0] reward_o;
  logic               dec_valid_o;

  int nvec = 0;
  int nmis = 0;
  bit fin  = 0;

  int mq [NV][NS];
  int mlvl;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  qvs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decide_i(decide_i),
    .slack_i(slack_i), .post_valid_i(post_valid_i), .post_slack_i(post_slack_i),
    .penalty_i(penalty_i), .vlevel_o(vlevel_o), .reward_o(reward_o),
    .dec_valid_o(dec_valid_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nmis++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_rwd(input int i, input int j);
    int a;
    int b;
    int r;
    a = 8 + i;
    b = 8 + j;
    r = ((a * a - b * b) * 32768) / (12 * 12 - 8 * 8);
    return (r > 32767) ? 32767 : r;
  endfunction

  function automatic int m_col(input int code);
    if (code == 0) return 0;
    if (code > NS) return NS - 1;
    return code - 1;
  endfunction

  function automatic int m_pick(input int c);
    int b = 0;
    for (int r = 1; r < NV; r++) if (mq[r][c] > mq[b][c]) b = r;
    return b;
  endfunction

  function automatic int fdiv4(input int d);
    return (d >= 0) ? d / 4 : -((-d + 3) / 4);
  endfunction

  function automatic void m_clear();
    for (int r = 0; r < NV; r++) for (int c = 0; c < NS; c++) mq[r][c] = 0;
    mlvl = NV - 1;
  endfunction

  // one control interval: decide, wait for strobe, deliver post reading
  task automatic step(input int slk, input int pslk, input int pen, input bit noise);
    int c;
    int j;
    int er;
    int x;
    int n;
    if (noise) begin  // R9 stray post while idle
      @(negedge clk); post_valid_i = 1; post_slack_i = 0; penalty_i = 15'h7fff;
      @(negedge clk); post_valid_i = 0;
    end
    c = m_col(slk); j = m_pick(c); er = m_rwd(mlvl, j);
    @(negedge clk); decide_i = 1; slack_i = 4'(slk);
    @(negedge clk); decide_i = 0;
    if (noise) begin decide_i = 1; slack_i = 4'((slk + 5) % 16); end  // R9 decide mid-scan
    for (int m = 0; m < NV - 1; m++) begin
      @(negedge clk); decide_i = 0;
    end
    chk("R4", "strobe early", int'(dec_valid_o), 0);
    @(negedge clk);
    chk("R4", "strobe", int'(dec_valid_o), 1);
    chk("R3", "level", int'(vlevel_o), j);
    chk("R5", "reward", int'(reward_o), er);
    if (noise) decide_i = 1;  // R9 decide while update pending
    post_valid_i = 1; post_slack_i = 4'(pslk); penalty_i = 15'(pen);
    @(negedge clk); post_valid_i = 0; decide_i = 0;
    chk("R4", "strobe fall", int'(dec_valid_o), 0);
    chk("R3", "level hold", int'(vlevel_o), j);
    x = er - ((pslk == 0) ? pen : 0) + mq[j][c];
    n = mq[mlvl][c] + fdiv4(x - mq[mlvl][c]);
    if (n > 32767) n = 32767;
    if (n < -32768) n = -32768;
    mq[mlvl][c] = n;
    mlvl = j;
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    m_clear();
    chk("R10", "level after start", int'(vlevel_o), NV - 1);
    chk("R10", "strobe after start", int'(dec_valid_o), 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset level", int'(vlevel_o), NV - 1);
    chk("R1", "reset strobe", int'(dec_valid_o), 0);
    chk("R1", "reset reward", int'(reward_o), 0);
  endtask

  task automatic t_first_and_update();
    step(3, 5, 1000, 0);   // R1 all zero -> level 0, R6 update without penalty
    step(3, 0, 1000, 0);   // R7 penalty applied
    step(3, 4, 20000, 0);  // R7 penalty ignored for positive slack
    step(3, 0, 0, 0);
    step(3, 7, 0, 0);      // R6 follow-on choices reflect learned scores
  endtask

  task automatic t_colmap();
    step(0, 2, 0, 0);      // R2 code 0 -> column 0
    step(1, 0, 9000, 0);   // R2 code 1 -> column 0
    step(0, 3, 0, 0);
    step(15, 1, 0, 0);     // R2 clamp high -> column 9
    step(10, 0, 5000, 0);
    step(12, 1, 0, 0);
  endtask

  task automatic t_ignore();
    step(4, 0, 3000, 1);   // R9
    step(4, 2, 0, 1);
    step(6, 0, 100, 1);
  endtask

  task automatic t_restart();
    // R10 start while update pending
    @(negedge clk); decide_i = 1; slack_i = 4'd2;
    @(negedge clk); decide_i = 0;
    repeat (NV) @(negedge clk);
    chk("R4", "strobe before abort", int'(dec_valid_o), 1);
    do_start();
    step(2, 3, 0, 0);
    chk("R10", "cleared table pick", mlvl, 0);
    // R10 start mid-scan abandons the decision
    @(negedge clk); decide_i = 1; slack_i = 4'd5;
    @(negedge clk); decide_i = 0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    m_clear();
    repeat (NV) begin
      @(negedge clk);
      chk("R10", "no strobe after abort", int'(dec_valid_o), 0);
    end
    chk("R10", "level after abort", int'(vlevel_o), NV - 1);
    step(5, 1, 0, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 40; k++) step(8, 0, 32767, 0);   // R8 negative limit
    for (int k = 0; k < 6; k++) step(8, 5, 0, 0);
  endtask

  task automatic t_random();
    int s;
    int p;
    int q;
    for (int k = 0; k < 150; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = int'(lf[3:0]);
      p = (lf[5:4] == 2'b00) ? 0 : 1 + int'(lf[9:6]) % NS;
      q = int'(lf[14:0]) ^ (k * 977);
      step(s, p, q & 32'h7fff, 0);  // R6 R7 R3 mixed
    end
  endtask

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_and_update();
    t_colmap();
    t_ignore();
    t_restart();
    do_start();
    t_saturate();
    do_start();
    t_random();
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      nvec++;
      nmis++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end
endmodule